// File: doc/BRIEF.md
# Edge-Triggered External Interrupt Unit

This block collects interrupt events from a small set of external pins and from a group of inputs watched for any change. Each pin responds to one edge, rising or falling, as software selects, and a valid edge latches a flag that stays set until software clears it. A change on any bit of the watched group latches one shared change flag. Flags are gated by per-source enables. Each source is then steered to a high-priority or a low-priority request output. The request outputs are qualified by a global enable.

The wake-up output asserts whenever any enabled source has a pending flag, whether or not the global enable is set. A sleeping core can therefore be woken by a source that is not allowed to interrupt it. All inputs are treated as asynchronous: they pass through a two-stage synchronizer, and edge or change detection starts only once the synchronizer and the detector history hold real samples after reset.

Software uses a small register port with a 2-bit address, a write strobe and a combinational read. Register 0 holds the edge selects. Register 1 holds the enables and the global enable. Register 2 holds the priorities. Register 3 holds the flags, and a 1 written to a flag bit clears that flag.

Top module: `ext_irq_unit`

## Requirements
- R1: After reset the registers read: address 0 = 0x0F (all edge selects 1), address 1 = 0x00, address 2 = 0x1F (all priorities high), address 3 = 0x00, and all three outputs are low.
- R2: With edge select bit i (address 0, bit i) at 1, a rising edge on pin i sets flag bit i (address 3, bit i), and a falling edge does not.
- R3: With edge select bit i at 0, a falling edge on pin i sets flag bit i, and a rising edge does not.
- R4: A set flag stays set until a write to address 3 with a 1 in its bit position; writing 0 there leaves it set.
- R5: A source whose enable bit is 0 (address 1, bit i for pin i, bit 4 for the change flag) drives neither request output nor the wake-up output, even with its flag set.
- R6: For pins 1 to 3 and the change flag, priority bit 1 (address 2, same bit position as the enable) routes the pending enabled source to the high request output, and priority bit 0 routes it to the low request output.
- R7: Pin 0 always routes to the high request output; address 2 bit 0 always reads 1, and writes to it have no effect.
- R8: The request outputs assert only when the global enable (address 1, bit 7) is 1; the wake-up output asserts for any enabled pending source regardless of the global enable.
- R9: Any change on any bit of the change group sets flag bit 4 of address 3.
- R10: When an input event and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R11: A flag becomes visible on the third rising clock edge after the input changes, and not on the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous edge-triggered interrupt pins |
| chg_i | input | CHG_W | Asynchronous inputs watched for any change |
| addr_i | input | 2 | Register select |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write data |
| rd_data_o | output | 8 | Read data for addr_i (combinational) |
| irq_hi_o | output | 1 | High-priority interrupt request |
| irq_lo_o | output | 1 | Low-priority interrupt request |
| wake_o | output | 1 | Wake-up request for a sleeping core |

## Verification
The bench builds the block with its defaults, four pins and a four-bit change group, so that every source and every register bit is covered. The bench sweeps every pin against both edge selects and both edge directions, and checks the flag one cycle before and in the cycle it is due. For each pin it also steps through all eight combinations of enable, priority and global enable, computing the expected level of both requests and the wake-up output from those bits. Each change-group bit is toggled in turn under both priorities, and one case lines up a clearing write with the cycle in which an edge lands.

// File: rtl/eiu_pkg.sv
// Package: shared constants and register selects of the external interrupt unit.
// Assumes a byte-wide register port with four addressable registers.
package eiu_pkg;
    localparam int DATA_W  = 8;
    localparam int GIE_BIT = 7;

    typedef enum logic [1:0] {
        REG_EDGE   = 2'd0,
        REG_ENABLE = 2'd1,
        REG_PRIO   = 2'd2,
        REG_FLAG   = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/eiu_sync.sv
// Module: eiu_sync
// Two-stage synchronizer for a vector of asynchronous inputs, plus a fill
// counter that reports when downstream detectors hold genuine history.
// Assumes each bit is an independent level; no bus coherence is needed.
module eiu_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         valid_o
);
    localparam int FILL = 3;
    localparam int CW   = $clog2(FILL + 1);

    logic [W-1:0]  s1_q;
    logic [CW-1:0] fill_q;

    // Two flops in series to resolve metastability.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_q <= '0;
            q_o  <= '0;
        end else begin
            s1_q <= d_i;
            q_o  <= s1_q;
        end
    end

    // Count cycles since reset until synchronizer and history are filled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
        end else if (fill_q != CW'(FILL)) begin
            fill_q <= fill_q + 1'b1;
        end
    end

    assign valid_o = (fill_q == CW'(FILL));
endmodule

// File: rtl/eiu_edge_det.sv
// Module: eiu_edge_det
// Per-bit edge detector with a selectable polarity: a 1 in rise_sel_i picks
// rising edges, a 0 picks falling edges. Emits a one-cycle hit per edge.
// Assumes sample_i is already synchronous to clk.
module eiu_edge_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    input  logic         valid_i,
    input  logic [W-1:0] rise_sel_i,
    output logic [W-1:0] hit_o
);
    logic [W-1:0] prev_q;

    // Hold the previous synchronized sample for comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sample_i;
    end

    for (genvar b = 0; b < W; b++) begin : g_bit
        logic rise, fall;
        assign rise     = sample_i[b] & ~prev_q[b];
        assign fall     = ~sample_i[b] & prev_q[b];
        assign hit_o[b] = valid_i & (rise_sel_i[b] ? rise : fall);

        // A selected edge cannot repeat on the very next cycle.
        AST_HIT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
            hit_o[b] |=> !hit_o[b]); // R2
    end
endmodule

// File: rtl/eiu_chg_det.sv
// Module: eiu_chg_det
// Group change detector: compares the synchronized group with the value
// captured one cycle earlier and reports any mismatch as a single hit.
// Assumes sample_i is already synchronous to clk.
module eiu_chg_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] sample_i,
    input  logic         valid_i,
    output logic         hit_o
);
    logic [W-1:0] cap_q;

    // Capture the group every cycle as the reference for the next.
    always_ff @(posedge clk) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= sample_i;
    end

    assign hit_o = valid_i & (sample_i != cap_q);
endmodule

// File: rtl/ext_irq_unit.sv
// Module: ext_irq_unit (top)
// Edge-triggered external interrupt unit: synchronizes pins and a change
// group, latches sticky flags, gates them by enables, routes them by
// priority to two request outputs and raises a wake-up for a sleeping core.
// Assumes NUM_PINS + 1 <= 7 so every source fits below the global enable bit.
module ext_irq_unit
    import eiu_pkg::*;
#(
    parameter int NUM_PINS = 4,
    parameter int CHG_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [CHG_W-1:0]    chg_i,
    input  logic [1:0]          addr_i,
    input  logic                wr_en_i,
    input  logic [DATA_W-1:0]   wr_data_i,
    output logic [DATA_W-1:0]   rd_data_o,
    output logic                irq_hi_o,
    output logic                irq_lo_o,
    output logic                wake_o
);
    localparam int NSRC   = NUM_PINS + 1;
    localparam int CHG_IX = NUM_PINS;
    localparam int SYN_W  = NUM_PINS + CHG_W;

    reg_sel_e            sel;
    logic [SYN_W-1:0]    syn_q;
    logic                syn_valid;
    logic [NUM_PINS-1:0] pin_hit;
    logic                chg_hit;
    logic [NSRC-1:0]     set_vec;
    logic [NSRC-1:0]     clr_vec;
    logic [NUM_PINS-1:0] edge_q;
    logic [NSRC-1:0]     en_q;
    logic [NSRC-1:1]     prio_q;
    logic [NSRC-1:0]     prio_eff;
    logic [NSRC-1:0]     flag_q;
    logic [NSRC-1:0]     pend;
    logic                gie_q;
    logic                unused_wr_bits;

    assign sel = reg_sel_e'(addr_i);

    eiu_sync #(.W(SYN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_i     ({chg_i, pin_i}),
        .q_o     (syn_q),
        .valid_o (syn_valid)
    );

    eiu_edge_det #(.W(NUM_PINS)) u_edge (
        .clk        (clk),
        .rst_n      (rst_n),
        .sample_i   (syn_q[NUM_PINS-1:0]),
        .valid_i    (syn_valid),
        .rise_sel_i (edge_q),
        .hit_o      (pin_hit)
    );

    eiu_chg_det #(.W(CHG_W)) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .sample_i (syn_q[SYN_W-1:NUM_PINS]),
        .valid_i  (syn_valid),
        .hit_o    (chg_hit)
    );

    assign set_vec = {chg_hit, pin_hit};
    assign clr_vec = (wr_en_i && sel == REG_FLAG) ? wr_data_i[NSRC-1:0] : '0;

    // Software-written configuration registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q <= '1;
            en_q   <= '0;
            prio_q <= '1;
            gie_q  <= 1'b0;
        end else if (wr_en_i) begin
            case (sel)
                REG_EDGE:   edge_q <= wr_data_i[NUM_PINS-1:0];
                REG_ENABLE: begin
                    en_q  <= wr_data_i[NSRC-1:0];
                    gie_q <= wr_data_i[GIE_BIT];
                end
                REG_PRIO:   prio_q <= wr_data_i[NSRC-1:1];
                default:    ;
            endcase
        end
    end

    // Sticky flags: hardware set takes precedence over a software clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= (flag_q & ~clr_vec) | set_vec;
    end

    // Combinational read mux.
    always_comb begin
        rd_data_o = '0;
        case (sel)
            REG_EDGE:   rd_data_o[NUM_PINS-1:0] = edge_q;
            REG_ENABLE: begin
                rd_data_o[NSRC-1:0] = en_q;
                rd_data_o[GIE_BIT]  = gie_q;
            end
            REG_PRIO:   rd_data_o[NSRC-1:0] = prio_eff;
            REG_FLAG:   rd_data_o[NSRC-1:0] = flag_q;
            default:    ;
        endcase
    end

    // Request routing and wake-up generation.
    assign prio_eff = {prio_q, 1'b1};
    assign pend     = flag_q & en_q;
    assign irq_hi_o = gie_q & |(pend & prio_eff);
    assign irq_lo_o = gie_q & |(pend & ~prio_eff);
    assign wake_o   = |pend;

    assign unused_wr_bits = ^wr_data_i[GIE_BIT-1:NSRC];

    for (genvar k = 0; k < NSRC; k++) begin : g_chk
        AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
            set_vec[k] |=> flag_q[k]); // R10
        AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag_q[k]) |-> $past(set_vec[k])); // R2
        AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[k] && !clr_vec[k]) |=> flag_q[k]); // R4
    end

    AST_PIN0_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q[0] && en_q[0] && gie_q) |-> irq_hi_o); // R7
    AST_GIE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        !gie_q |-> !(irq_hi_o || irq_lo_o)); // R8
    AST_REQ_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_hi_o || irq_lo_o) |-> wake_o); // R8
    AST_CHG_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        chg_hit |=> flag_q[CHG_IX]); // R9
endmodule

// File: tb/sim_ext_irq_unit.sv
module sim_ext_irq_unit;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] pin_i = '0;
    logic [3:0] chg_i = '0;
    logic [1:0] addr_i = '0;
    logic       wr_en_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic [7:0] rd_data_o;
    logic       irq_hi_o, irq_lo_o, wake_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    ext_irq_unit u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .chg_i(chg_i),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
        .rd_data_o(rd_data_o), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o),
        .wake_o(wake_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [7:0] v);
        addr_i = a;
        #1 v = rd_data_o;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1: reset values
        rd(2'd0, v); chk("R1 edge", v, 8'h0F);
        rd(2'd1, v); chk("R1 enable", v, 8'h00);
        rd(2'd2, v); chk("R1 prio", v, 8'h1F);
        rd(2'd3, v); chk("R1 flag", v, 8'h00);
        chk("R1 outputs", {irq_hi_o, irq_lo_o, wake_o}, 0);
        step(4);

        // R2 / R3 / R11 / R4: pin x polarity x direction sweep
        for (int i = 0; i < 4; i++) begin
            for (int pol = 0; pol < 2; pol++) begin
                for (int dir = 0; dir < 2; dir++) begin
                    int expf;
                    wr(2'd0, pol ? 8'h0F : 8'h00);
                    pin_i[i] = (dir == 0);
                    step(4);
                    wr(2'd3, 8'h1F);
                    rd(2'd3, v); chk("R4 cleared", v, 0);
                    pin_i[i] = (dir == 1);
                    step(2);
                    rd(2'd3, v); chk("R11 not yet", v, 0);
                    step(1);
                    expf = (pol == dir) ? (1 << i) : 0;
                    rd(2'd3, v);
                    chk(pol ? "R2 rising select" : "R3 falling select", v, expf);
                    step(3);
                    wr(2'd3, 8'h00);
                    rd(2'd3, v); chk("R4 sticky", v, expf);
                end
            end
        end

        // R5 / R6 / R7 / R8: enable x priority x global sweep per pin
        wr(2'd0, 8'h0F);
        pin_i = '0;
        step(4);
        wr(2'd3, 8'h1F);
        for (int i = 0; i < 4; i++) begin
            pin_i[i] = 1'b1;
            step(3);
            rd(2'd3, v); chk("R2 single pin", v, 1 << i);
            for (int en = 0; en < 2; en++) begin
                for (int pr = 0; pr < 2; pr++) begin
                    for (int g = 0; g < 2; g++) begin
                        int eh, el;
                        wr(2'd2, pr ? 8'(1 << i) : 8'h00);
                        wr(2'd1, 8'((g << 7) | (en << i)));
                        eh = g & en & ((i == 0) | pr);
                        el = g & en & (i != 0) & (pr == 0);
                        chk(i == 0 ? "R7 high route" : "R6 high route", irq_hi_o, eh);
                        chk(g ? "R6 low route" : "R8 gated low", irq_lo_o, el);
                        chk(en ? "R8 wake" : "R5 disabled wake", wake_o, en);
                        rd(2'd2, v);
                        chk("R7 prio readback", v, (pr ? (1 << i) : 0) | 1);
                    end
                end
            end
            wr(2'd1, 8'h00);
            pin_i[i] = 1'b0;
            step(4);
            wr(2'd3, 8'h1F);
        end

        // R9: each change-group bit sets the shared flag, routed both ways
        for (int b = 0; b < 4; b++) begin
            chg_i[b] = ~chg_i[b];
            step(3);
            rd(2'd3, v); chk("R9 change flag", v, 8'h10);
            wr(2'd1, 8'h90);
            wr(2'd2, 8'h10);
            chk("R9 change high", {irq_hi_o, irq_lo_o}, 2'b10);
            wr(2'd2, 8'h00);
            chk("R9 change low", {irq_hi_o, irq_lo_o}, 2'b01);
            wr(2'd1, 8'h00);
            wr(2'd3, 8'h1F);
        end
        step(5);
        rd(2'd3, v); chk("R9 quiet group", v, 0);

        // R10: clear write in the same cycle as the flag set
        pin_i[1] = 1'b1;
        step(2);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R10 set wins", v, 8'h02);
        wr(2'd3, 8'h02);
        rd(2'd3, v); chk("R4 later clear", v, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule